// File: doc/BRIEF.md
# Dual-Press Reset Manager

This block watches the reset line coming from a host processor socket and decides what that reset means to a companion compute module. The host line is synchronised into the local 50 MHz domain. It is then filtered so that only a level held for a minimum time counts as a press. The assertion of each filtered press is treated as a press event.

A lone press gives the companion module a soft reset. This output stays high for as long as the filtered press lasts, so the application can reinitialise. If a second press arrives while the one-second window opened by the first press is still running, the block raises a hard power-management reset instead. That reset lasts a fixed 100 ms. Presses during that pulse are ignored, and afterwards the block is idle again. If the window runs out with no second press, the next press counts as a first press.

The filter time, window length and hard pulse length are parameters. Their defaults are derived from the 50 MHz clock: 1 ms, 1 s and 100 ms.

Top module: `dual_press_reset`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, `soft_rst_o` and `hard_rst_o` are both 0 until a press is recognised.
- R2: The host reset is active low (`host_rst_n` = 0 means pressed). A low level that lasts fewer than `DEBOUNCE_CYCLES` cycles after synchronisation is not a press and changes neither output.
- R3: A first press drives `soft_rst_o` to 1. It stays 1 while the filtered press lasts, even past the window, and returns to 0 after the filtered release.
- R4: A press whose filtered assertion comes no more than `WINDOW_CYCLES` cycles after the filtered assertion of the first press drives `hard_rst_o` to 1. `soft_rst_o` stays 0 for that press.
- R5: `hard_rst_o` stays 1 for exactly `HARD_CYCLES` consecutive cycles, then returns to 0.
- R6: Presses that occur while `hard_rst_o` is 1 are ignored: the pulse is neither lengthened nor restarted, and no soft reset is raised. After the pulse, the next press is a first press.
- R7: If `WINDOW_CYCLES` cycles pass after a first press with no second press, the block becomes idle, and a later press produces `soft_rst_o`, not `hard_rst_o`.
- R8: `soft_rst_o` and `hard_rst_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset of this block |
| host_rst_n | input | 1 | Asynchronous host reset line, low while pressed |
| soft_rst_o | output | 1 | Soft reset to the companion module, high while a first press lasts |
| hard_rst_o | output | 1 | Hard power-management reset, high for one fixed pulse |

## Verification
Several properties are checked on every cycle:
- the two outputs are mutually exclusive;
- a hard pulse begins only from the armed window on a new press event;
- the soft reset drops one cycle after the filtered press goes away;
- an expired window always returns to idle;
- the filter's press event lasts a single cycle.

Other behaviours need the bench's scenarios, because they depend on stimulus histories. These are: rejection of short glitches, the exact pulse length, the ignoring of presses during the pulse, and the choice between soft and hard reset depending on how far apart two presses fall. The bench's behavioural model covers them, together with steady-state checks taken after each scenario.

// File: rtl/drc_pkg.sv
// Package: shared types for the dual-press reset manager.
// Assumes: a single clock domain after the input synchroniser.
package drc_pkg;

    // Press sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a first press
        ST_ARMED = 2'd1,   // window running after a first press
        ST_HARD  = 2'd2    // hard reset pulse in progress
    } drc_state_t;

endpackage

// File: rtl/drc_sync.sv
// Module: drc_sync
// Brings an asynchronous level into the clock domain through a chain of flops.
// Assumes: STAGES >= 2; the reset value is the inactive level of the signal.
module drc_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the input through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/drc_debounce.sv
// Module: drc_debounce
// Accepts a new level only after the input has differed from the current
// level for STABLE_CYCLES consecutive samples. Emits a one-cycle event
// on each accepted assertion.
// Assumes: din is already synchronous; STABLE_CYCLES >= 2.
module drc_debounce #(
    parameter int STABLE_CYCLES = 50_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    localparam int CW = $clog2(STABLE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive disagreeing samples and accept the level at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= 1'b0;
            run_cnt <= '0;
            rise    <= 1'b0;
        end else begin
            rise <= 1'b0;
            if (din == level) begin
                run_cnt <= '0;
            end else if (run_cnt == LAST) begin
                level   <= din;
                run_cnt <= '0;
                rise    <= din;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R2: a press event lasts exactly one cycle
    a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R2: a press event only accompanies an accepted asserted level
    a_r2_rise_with_level: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> level);

endmodule

// File: rtl/drc_sequencer.sv
// Module: drc_sequencer
// Classifies filtered press events. A first press opens a window and raises
// the soft reset while pressed. A second press inside the window starts a
// fixed hard reset pulse, during which presses are ignored.
// Assumes: pressed/press_rise come from the debouncer; both limits >= 2.
module drc_sequencer
    import drc_pkg::*;
#(
    parameter int WINDOW_CYCLES = 50_000_000,
    parameter int HARD_CYCLES   = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pressed,
    input  logic press_rise,
    output logic soft_rst,
    output logic hard_rst
);
    localparam int WW = $clog2(WINDOW_CYCLES);
    localparam int HW = $clog2(HARD_CYCLES);
    localparam logic [WW-1:0] WLAST = WW'(WINDOW_CYCLES - 1);
    localparam logic [HW-1:0] HLAST = HW'(HARD_CYCLES - 1);

    drc_state_t    state;
    logic [WW-1:0] win_cnt;
    logic [HW-1:0] hard_cnt;
    logic          soft_q;
    logic          hard_q;

    // Step through idle, window and hard pulse phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            win_cnt  <= '0;
            hard_cnt <= '0;
            hard_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (press_rise) begin
                        state   <= ST_ARMED;
                        win_cnt <= '0;
                    end
                end
                ST_ARMED: begin
                    if (press_rise) begin
                        state    <= ST_HARD;
                        hard_cnt <= '0;
                        hard_q   <= 1'b1;
                    end else if (win_cnt == WLAST) begin
                        state <= ST_IDLE;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                ST_HARD: begin
                    if (hard_cnt == HLAST) begin
                        state  <= ST_IDLE;
                        hard_q <= 1'b0;
                    end else begin
                        hard_cnt <= hard_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Raise soft reset on a first press and hold it while the press lasts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else if (press_rise && state == ST_IDLE) begin
            soft_q <= 1'b1;
        end else if (!pressed) begin
            soft_q <= 1'b0;
        end
    end

    assign soft_rst = soft_q;
    assign hard_rst = hard_q;

    // R8: the two resets never overlap
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(soft_q && hard_q));

    // R4: a hard pulse starts only from a new press inside the window
    a_r4_hard_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_q) |-> $past(state == ST_ARMED && press_rise));

    // R3: soft reset drops after the filtered press ends
    a_r3_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pressed |=> !soft_q);

    // R7: an expired window with no press returns to idle
    a_r7_window_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && win_cnt == WLAST && !press_rise) |=> state == ST_IDLE);

    // R6: the end of a hard pulse leaves the block idle
    a_r6_hard_exit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hard_q) |-> state == ST_IDLE);

endmodule

// File: rtl/dual_press_reset.sv
// Module: dual_press_reset
// Top of the dual-press reset manager: synchroniser, press filter and
// press sequencer. Converts the active-low host reset into an active-high
// "pressed" signal before filtering.
// Assumes: clk runs at CLK_HZ; rst_n is synchronous to clk.
module dual_press_reset #(
    parameter int CLK_HZ          = 50_000_000,
    parameter int DEBOUNCE_CYCLES = CLK_HZ / 1000,
    parameter int WINDOW_CYCLES   = CLK_HZ,
    parameter int HARD_CYCLES     = CLK_HZ / 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_rst_n,
    output logic soft_rst_o,
    output logic hard_rst_o
);
    logic press_async;
    logic press_sync;
    logic press_level;
    logic press_rise;

    assign press_async = ~host_rst_n;

    drc_sync #(
        .STAGES    (2),
        .RESET_VAL (1'b0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (press_async),
        .dout  (press_sync)
    );

    drc_debounce #(
        .STABLE_CYCLES (DEBOUNCE_CYCLES)
    ) u_debounce (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (press_sync),
        .level (press_level),
        .rise  (press_rise)
    );

    drc_sequencer #(
        .WINDOW_CYCLES (WINDOW_CYCLES),
        .HARD_CYCLES   (HARD_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pressed    (press_level),
        .press_rise (press_rise),
        .soft_rst   (soft_rst_o),
        .hard_rst   (hard_rst_o)
    );

endmodule

// File: tb/dual_press_reset_test.sv
module dual_press_reset_test;
    localparam int DB   = 4;
    localparam int WIN  = 60;
    localparam int HOLD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_rst_n = 1'b1;
    logic soft_rst_o;
    logic hard_rst_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_press_reset #(
        .CLK_HZ          (1000),
        .DEBOUNCE_CYCLES (DB),
        .WINDOW_CYCLES   (WIN),
        .HARD_CYCLES     (HOLD)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rst_n (host_rst_n),
        .soft_rst_o (soft_rst_o),
        .hard_rst_o (hard_rst_o)
    );

    // Behavioural reference: delay queue, run counter, phase integer
    int q_sync[$];
    int m_lvl, m_run, m_rise, m_phase, m_win, m_hold;
    bit m_soft, m_hard;
    bit nsoft;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_sync = '{0, 0};
            m_lvl = 0; m_run = 0; m_rise = 0;
            m_phase = 0; m_win = 0; m_hold = 0;
            m_soft = 0; m_hard = 0;
        end else begin
            nsoft = m_soft;
            if (m_rise != 0 && m_phase == 0) nsoft = 1;
            else if (m_lvl == 0) nsoft = 0;
            if (m_phase == 0) begin
                if (m_rise != 0) begin m_phase = 1; m_win = 0; end
            end else if (m_phase == 1) begin
                if (m_rise != 0) begin m_phase = 2; m_hold = 0; m_hard = 1; end
                else if (m_win == WIN - 1) m_phase = 0;
                else m_win++;
            end else begin
                if (m_hold == HOLD - 1) begin m_phase = 0; m_hard = 0; end
                else m_hold++;
            end
            m_soft = nsoft;
            m_rise = 0;
            if (q_sync[1] == m_lvl) m_run = 0;
            else if (m_run == DB - 1) begin
                m_lvl = q_sync[1]; m_run = 0; m_rise = q_sync[1];
            end else m_run++;
            q_sync = '{(host_rst_n ? 0 : 1), q_sync[0]};
        end
    end

    // Compare against the model every cycle, away from the edge
    int hard_seen;
    bit soft_in_hard;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (hard_rst_o !== m_hard) begin
                fails++;
                $display("FAIL R5 hard per-cycle: actual %0b expected %0b at %0t", hard_rst_o, m_hard, $time);
            end
            checks++;
            if (soft_rst_o !== m_soft) begin
                fails++;
                $display("FAIL R3 soft per-cycle: actual %0b expected %0b at %0t", soft_rst_o, m_soft, $time);
            end
            checks++;
            if (soft_rst_o && hard_rst_o) begin
                fails++;
                $display("FAIL R8 overlap: actual 11 expected not both at %0t", $time);
            end
            if (hard_rst_o) hard_seen++;
            if (hard_rst_o && soft_rst_o) soft_in_hard = 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic press(input int low_n, input int high_n);
        @(negedge clk);
        host_rst_n = 1'b0;
        cycles(low_n);
        host_rst_n = 1'b1;
        cycles(high_n);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            done = 1'b1;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cycles(5);
        chk(soft_rst_o == 0 && hard_rst_o == 0, "R1 outputs in reset", {soft_rst_o, hard_rst_o}, 0);
        @(negedge clk) rst_n = 1'b1;
        cycles(3);
        chk(soft_rst_o == 0 && hard_rst_o == 0, "R1 outputs after reset", {soft_rst_o, hard_rst_o}, 0);

        // R2: glitches shorter than the filter
        press(DB - 1, 20);
        chk(soft_rst_o == 0 && hard_rst_o == 0, "R2 short glitch ignored", {soft_rst_o, hard_rst_o}, 0);
        press(1, 20);
        chk(soft_rst_o == 0 && hard_rst_o == 0, "R2 one-cycle glitch ignored", {soft_rst_o, hard_rst_o}, 0);

        // R3: single press
        @(negedge clk) host_rst_n = 1'b0;
        cycles(15);
        chk(soft_rst_o == 1, "R3 soft during press", soft_rst_o, 1);
        chk(hard_rst_o == 0, "R3 no hard on first press", hard_rst_o, 0);
        host_rst_n = 1'b1;
        cycles(15);
        chk(soft_rst_o == 0, "R3 soft after release", soft_rst_o, 0);
        cycles(WIN + 20);

        // R4, R5, R6: double press, then a press during the pulse
        hard_seen = 0;
        soft_in_hard = 0;
        press(10, 10);
        press(8, 6);
        chk(hard_rst_o == 1, "R4 hard after second press", hard_rst_o, 1);
        chk(soft_rst_o == 0, "R4 no soft on second press", soft_rst_o, 0);
        press(6, 40);
        chk(hard_seen == HOLD, "R5 hard pulse length", hard_seen, HOLD);
        chk(hard_seen == HOLD && !soft_in_hard, "R6 press in pulse ignored", hard_seen, HOLD);
        chk(hard_rst_o == 0, "R5 hard released", hard_rst_o, 0);
        cycles(WIN + 20);
        @(negedge clk) host_rst_n = 1'b0;
        cycles(12);
        chk(soft_rst_o == 1 && hard_rst_o == 0, "R6 first press after pulse", {soft_rst_o, hard_rst_o}, 2);
        host_rst_n = 1'b1;
        cycles(15);

        // R7: window expires between two presses
        cycles(WIN + 10);
        press(8, WIN + 10);
        @(negedge clk) host_rst_n = 1'b0;
        cycles(12);
        chk(soft_rst_o == 1 && hard_rst_o == 0, "R7 late press is first press", {soft_rst_o, hard_rst_o}, 2);
        host_rst_n = 1'b1;
        cycles(WIN + 20);

        // R3: a press held past the window keeps soft asserted
        @(negedge clk) host_rst_n = 1'b0;
        cycles(WIN + 40);
        chk(soft_rst_o == 1, "R3 long press soft held", soft_rst_o, 1);
        host_rst_n = 1'b1;
        cycles(15);
        chk(soft_rst_o == 0 && hard_rst_o == 0, "R3 long press release", {soft_rst_o, hard_rst_o}, 0);

        // R4 boundary: second press close to the end of the window
        cycles(WIN + 10);
        press(8, WIN - 20);
        press(10, 30);
        chk(hard_seen == 2 * HOLD, "R4 late second press in window", hard_seen, 2 * HOLD);
        cycles(WIN);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule